// File: doc/BRIEF.md
# Receive gain sequencer

This block is the digital control for a receive chain with six gain stages: a low-noise amplifier, a mixer, three coarse variable-gain amplifiers and a fine-step output stage. A baseband controller sends one 16-bit gain word over a dedicated three-wire serial link: a clock, a data line, and an active-low select for the receive gain word. A second active-low select uses the same clock and data lines to load a transmit-level word. The block splits the gain word into a 2-bit select code for each coarse stage and a 3-bit fine code. It also keeps a programmable output gain offset.

Coarse steps are 6 dB each, and every coarse stage has four settings. The total number of coarse steps is placed at the front of the chain first: the low-noise amplifier is filled before the mixer, and the mixer before the first variable-gain amplifier. The fine code covers the remainder in 0.76 dB steps. Each applied gain word starts an offset-correction pass that visits every stage in order.

The offset-correction pass uses a request/done handshake for each stage. The request is the valid side and the done line is the ready side. A request stays asserted, with no time limit, until the clock edge that samples its done bit. Only one request is active at a time. A done bit seen while its own request is low has no effect.

Top module: `rx_gain_sequencer`

## Requirements
- R1: A frame is a group of bits sampled on rising edges of `ser_clk` while exactly one select is low. Bits arrive MSB first. A frame takes effect only when its select returns high after exactly 16 bits. A frame with 15 bits, or with 17 or more, changes nothing.
- R2: Layout of the gain word: bits [15:12] hold the coarse step total T (0..15). Bits [11:9] hold the fine code. Bit 8 is the offset-write flag. Bits [3:0] hold the offset code. Bits [7:4] are ignored.
- R3: Stage index i runs 0 = low-noise amplifier, 1 = mixer, 2..4 = variable-gain amplifiers 1..3. Stage i receives code min(3, max(0, T-3i)). Code 0..3 means 0/6/12/18 dB, or 4/10/16/22 dB for the mixer. `vga_code` packs amplifier 1 in bits [1:0], amplifier 2 in [3:2] and amplifier 3 in [5:4].
- R4: `fine_code` takes the word's fine field. Each code step is 0.76 dB.
- R5: `out_ofs` is loaded only when the offset-write flag is 1. Codes above 9 load as 9. Code k stands for about -1.5 + 0.76k dB.
- R6: Gain outputs update on the first `clk` edge that sees the select high after a valid frame. On that same edge `oc_req` becomes 6'b000001.
- R7: `oc_req` is one-hot or zero. Bit order is low-noise amplifier, mixer, amplifiers 1..3, fine stage (bits 0..5). The active request holds until the edge that samples its `oc_done` bit high. On that edge the request moves to the next bit. After bit 5 it goes to zero.
- R8: An `oc_done` bit whose request is low has no effect.
- R9: A gain word applied while a pass is running restarts the pass at bit 0.
- R10: A valid frame sent under `txl_sel_n` loads `tx_level` on the release edge. It leaves the gain outputs and `oc_req` unchanged.
- R11: If both selects are low at the same time during a frame, that frame is discarded.
- R12: After reset, every code, `out_ofs`, `oc_req` and `tx_level` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock. The serial lines are sampled with it. |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock. It must be slower than `clk`. |
| ser_data | input | 1 | Serial data, MSB first |
| rxg_sel_n | input | 1 | Active-low select for the gain word |
| txl_sel_n | input | 1 | Active-low select for the transmit-level word |
| oc_done | input | 6 | Offset-correction done, one bit per stage |
| lna_code | output | 2 | Low-noise amplifier gain select |
| mix_code | output | 2 | Mixer gain select |
| vga_code | output | 6 | Three variable-gain amplifier selects |
| fine_code | output | 3 | Fine-step stage select |
| out_ofs | output | 4 | Output gain offset code |
| oc_req | output | 6 | One-hot offset-correction request |
| tx_level | output | 16 | Last transmit-level word |

## Verification
Gain codes, `out_ofs`, `tx_level` and the first request are all due on the rising edge of `clk` that samples the select's release. Each request step is due one edge after the edge that samples the matching done bit. A behavioural model in the bench steps once on every rising edge, using the same input values the design sees. All outputs are compared with the model at every falling edge, so a result that is a cycle early or late is reported. Directed checks run one falling edge after each release and after each done pulse, which is the cycle in which the requirements place the change.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int WORD_W   = 16;
  localparam int CODE_W   = 2;
  localparam int STEPS    = 3;
  localparam int N_COARSE = 5;
  localparam int N_OC     = N_COARSE + 1;
  localparam int TOT_W    = 4;
  localparam int FINE_W   = 3;
  localparam int OFS_W    = 4;
  localparam int OFS_MAX  = 9;
  localparam int TOT_LSB  = 12;
  localparam int FINE_LSB = 9;
  localparam int OFS_WR   = 8;
  localparam int OFS_LSB  = 0;

  typedef struct packed {
    logic [TOT_W-1:0]  tot;
    logic [FINE_W-1:0] fine;
    logic              ofs_wr;
    logic [OFS_W-1:0]  ofs;
  } gain_word_t;

  function automatic gain_word_t split_word(input logic [WORD_W-1:0] w);
    gain_word_t g;
    g.tot    = w[TOT_LSB +: TOT_W];
    g.fine   = w[FINE_LSB +: FINE_W];
    g.ofs_wr = w[OFS_WR];
    g.ofs    = w[OFS_LSB +: OFS_W];
    return g;
  endfunction

  function automatic logic [CODE_W-1:0] stage_code(input logic [TOT_W-1:0] tot,
                                                   input int idx);
    int rem;
    rem = int'(tot) - idx * STEPS;
    if (rem < 0) rem = 0;
    if (rem > STEPS) rem = STEPS;
    return CODE_W'(rem);
  endfunction
endpackage

// File: rtl/rxg_ser_rx.sv
module rxg_ser_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_data,
  input  logic         rx_sel_n,
  input  logic         tx_sel_n,
  output logic [W-1:0] word,
  output logic         rx_load,
  output logic         tx_load
);
  localparam int CNT_W = $clog2(W + 2);

  logic             sck_q, rx_q, tx_q, bad;
  logic [CNT_W-1:0] cnt;
  logic             rise, both_hi, both_lo, full;

  assign rise    = ser_clk & ~sck_q;
  assign both_hi = rx_sel_n & tx_sel_n;
  assign both_lo = ~rx_sel_n & ~tx_sel_n;
  assign full    = (cnt == CNT_W'(W)) & ~bad;
  assign rx_load = ~rx_q & tx_q & both_hi & full;
  assign tx_load = rx_q & ~tx_q & both_hi & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      rx_q  <= 1'b1;
      tx_q  <= 1'b1;
      bad   <= 1'b0;
      cnt   <= '0;
      word  <= '0;
    end else begin
      sck_q <= ser_clk;
      rx_q  <= rx_sel_n;
      tx_q  <= tx_sel_n;
      if (both_hi) begin
        cnt <= '0;
        bad <= 1'b0;
      end else if (both_lo) begin
        bad <= 1'b1;
      end else if (rise) begin
        word <= {word[W-2:0], ser_data};
        if (cnt != CNT_W'(W + 1)) cnt <= cnt + 1'b1;
      end
    end
  end

  assert_one_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_load && tx_load));
endmodule

// File: rtl/rxg_gain_map.sv
module rxg_gain_map
  import rxg_pkg::*;
#(
  parameter int NS = N_COARSE
) (
  input  logic [TOT_W-1:0]       tot,
  output logic [NS*CODE_W-1:0]   codes
);
  for (genvar s = 0; s < NS; s++) begin : g_stage
    assign codes[s*CODE_W +: CODE_W] = stage_code(tot, s);
  end
endmodule

// File: rtl/rxg_oc_seq.sv
module rxg_oc_seq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] done,
  output logic [N-1:0] req
);
  logic hit;
  assign hit = |(req & done);

  always_ff @(posedge clk) begin
    if (!rst_n)     req <= '0;
    else if (start) req <= {{(N-1){1'b0}}, 1'b1};
    else if (hit)   req <= req << 1;
  end

  assert_req_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0 && (req & done) == '0 && !start) |=> req == $past(req));
  assert_req_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & done) != '0 && !start) |=> req == ($past(req) << 1));
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> req == {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/rx_gain_sequencer.sv
module rx_gain_sequencer
  import rxg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_clk,
  input  logic                         ser_data,
  input  logic                         rxg_sel_n,
  input  logic                         txl_sel_n,
  input  logic [N_OC-1:0]              oc_done,
  output logic [CODE_W-1:0]            lna_code,
  output logic [CODE_W-1:0]            mix_code,
  output logic [(N_COARSE-2)*CODE_W-1:0] vga_code,
  output logic [FINE_W-1:0]            fine_code,
  output logic [OFS_W-1:0]             out_ofs,
  output logic [N_OC-1:0]              oc_req,
  output logic [WORD_W-1:0]            tx_level
);
  localparam int CW_ALL = N_COARSE * CODE_W;

  logic [WORD_W-1:0] word;
  logic              rx_load, tx_load;
  gain_word_t        gw;
  logic [CW_ALL-1:0] codes_d, coarse_q;

  rxg_ser_rx #(.W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .rx_sel_n(rxg_sel_n), .tx_sel_n(txl_sel_n),
    .word(word), .rx_load(rx_load), .tx_load(tx_load)
  );

  assign gw = split_word(word);

  rxg_gain_map #(.NS(N_COARSE)) u_map (.tot(gw.tot), .codes(codes_d));

  rxg_oc_seq #(.N(N_OC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(rx_load), .done(oc_done), .req(oc_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_q  <= '0;
      fine_code <= '0;
      out_ofs   <= '0;
      tx_level  <= '0;
    end else begin
      if (rx_load) begin
        coarse_q  <= codes_d;
        fine_code <= gw.fine;
        if (gw.ofs_wr)
          out_ofs <= (gw.ofs > OFS_W'(OFS_MAX)) ? OFS_W'(OFS_MAX) : gw.ofs;
      end
      if (tx_load) tx_level <= word;
    end
  end

  assign lna_code = coarse_q[0 +: CODE_W];
  assign mix_code = coarse_q[CODE_W +: CODE_W];
  assign vga_code = coarse_q[CW_ALL-1:2*CODE_W];

  for (genvar s = 1; s < N_COARSE; s++) begin : g_order
    assert_front_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (coarse_q[s*CODE_W +: CODE_W] != '0) |->
        (coarse_q[(s-1)*CODE_W +: CODE_W] == CODE_W'(STEPS)));
  end

  assert_ofs_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ofs <= OFS_W'(OFS_MAX));
  assert_tx_keeps_gain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (coarse_q == $past(coarse_q) && fine_code == $past(fine_code)));
endmodule

// File: tb/rx_gain_sequencer_tb.sv
module rx_gain_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_data = 1'b0;
  logic        rxg_sel_n = 1'b1, txl_sel_n = 1'b1;
  logic [5:0]  oc_done, man_done = '0;
  logic        auto_ack = 1'b0;
  logic [1:0]  lna_code, mix_code;
  logic [5:0]  vga_code;
  logic [2:0]  fine_code;
  logic [3:0]  out_ofs;
  logic [5:0]  oc_req;
  logic [15:0] tx_level;

  int checks = 0, failures = 0, cycles = 0;
  bit done_all = 1'b0;

  assign oc_done = auto_ack ? oc_req : man_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_gain_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .rxg_sel_n(rxg_sel_n), .txl_sel_n(txl_sel_n), .oc_done(oc_done),
    .lna_code(lna_code), .mix_code(mix_code), .vga_code(vga_code),
    .fine_code(fine_code), .out_ofs(out_ofs), .oc_req(oc_req), .tx_level(tx_level)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped on each rising edge
  int m_cnt, m_word, e_stage, e_fine, e_ofs, e_tx;
  int e_c[5];
  bit m_sck, m_rxq, m_txq, m_bad;

  always @(posedge clk) begin
    bit rise, hi, lo, rx_rel, tx_rel;
    if (!rst_n) begin
      m_cnt = 0; m_word = 0; m_bad = 0; m_sck = 0; m_rxq = 1; m_txq = 1;
      e_stage = -1; e_fine = 0; e_ofs = 0; e_tx = 0;
      foreach (e_c[i]) e_c[i] = 0;
    end else begin
      rise = ser_clk && !m_sck;
      hi = rxg_sel_n && txl_sel_n;
      lo = !rxg_sel_n && !txl_sel_n;
      rx_rel = !m_rxq && m_txq && hi && m_cnt == 16 && !m_bad;
      tx_rel = m_rxq && !m_txq && hi && m_cnt == 16 && !m_bad;
      if (rx_rel) begin
        int t, o;
        t = (m_word >> 12) & 15;
        foreach (e_c[i]) begin
          int c;
          c = t - 3 * i;
          e_c[i] = c < 0 ? 0 : (c > 3 ? 3 : c);
        end
        e_fine = (m_word >> 9) & 7;
        if ((m_word >> 8) & 1) begin
          o = m_word & 15;
          e_ofs = o > 9 ? 9 : o;
        end
        e_stage = 0;
      end else if (e_stage >= 0 && oc_done[e_stage]) begin
        e_stage = e_stage == 5 ? -1 : e_stage + 1;
      end
      if (tx_rel) e_tx = m_word;
      if (hi) begin m_cnt = 0; m_bad = 0; end
      else if (lo) m_bad = 1;
      else if (rise) begin
        m_word = ((m_word << 1) | int'(ser_data)) & 16'hFFFF;
        if (m_cnt < 17) m_cnt++;
      end
      m_sck = ser_clk; m_rxq = rxg_sel_n; m_txq = txl_sel_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_all) begin
      check("R3 model lna", int'(lna_code), e_c[0]);
      check("R3 model mix", int'(mix_code), e_c[1]);
      check("R3 model vga", int'(vga_code), e_c[2] | (e_c[3] << 2) | (e_c[4] << 4));
      check("R4 model fine", int'(fine_code), e_fine);
      check("R5 model ofs", int'(out_ofs), e_ofs);
      check("R7 model req", int'(oc_req), e_stage < 0 ? 0 : (1 << e_stage));
      check("R10 model tx", int'(tx_level), e_tx);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done_all) begin
      done_all = 1'b1;
      failures++;
      $display("FAIL R7 watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input bit use_tx, input int nbits, input logic [31:0] w,
                      input bit clash);
    @(negedge clk);
    if (use_tx) txl_sel_n = 1'b0; else rxg_sel_n = 1'b0;
    @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = w[i];
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
      if (clash && i == 8) begin
        if (use_tx) rxg_sel_n = 1'b0; else txl_sel_n = 1'b0;
        @(negedge clk);
        if (use_tx) rxg_sel_n = 1'b1; else txl_sel_n = 1'b1;
      end
    end
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
    if (use_tx) txl_sel_n = 1'b1; else rxg_sel_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset lna", int'(lna_code), 0);
    check("R12 reset req", int'(oc_req), 0);
    check("R12 reset tx", int'(tx_level), 0);
    check("R12 reset ofs", int'(out_ofs), 0);

    send(0, 16, 32'h7B04, 0);
    check("R1 R3 lna", int'(lna_code), 3);
    check("R3 mix", int'(mix_code), 3);
    check("R3 vga", int'(vga_code), 1);
    check("R4 fine", int'(fine_code), 5);
    check("R5 ofs load", int'(out_ofs), 4);
    check("R6 first req", int'(oc_req), 1);

    man_done = 6'b001000;
    @(negedge clk);
    man_done = '0;
    check("R8 stray done", int'(oc_req), 1);
    man_done = 6'b000001;
    @(negedge clk);
    man_done = '0;
    check("R7 step", int'(oc_req), 2);
    @(negedge clk);
    check("R7 hold", int'(oc_req), 2);
    auto_ack = 1'b1;
    repeat (8) @(negedge clk);
    auto_ack = 1'b0;
    check("R7 pass end", int'(oc_req), 0);

    send(0, 16, 32'hFE0F, 0);
    check("R3 full vga", int'(vga_code), 63);
    check("R4 fine max", int'(fine_code), 7);
    check("R5 no write", int'(out_ofs), 4);

    send(0, 16, 32'h010F, 0);
    check("R3 zero lna", int'(lna_code), 0);
    check("R5 saturate", int'(out_ofs), 9);

    send(0, 16, 32'h60F0, 0);
    check("R2 reserved bits", int'(out_ofs), 9);
    check("R2 mix", int'(mix_code), 3);
    check("R2 vga", int'(vga_code), 0);

    send(0, 16, 32'hA000, 0);
    check("R3 ten vga", int'(vga_code), 7);
    man_done = 6'b000001;
    @(negedge clk);
    man_done = 6'b000010;
    @(negedge clk);
    man_done = '0;
    check("R7 stage2", int'(oc_req), 4);
    send(0, 16, 32'h3000, 0);
    check("R9 restart", int'(oc_req), 1);
    check("R9 mix", int'(mix_code), 0);

    send(0, 15, 32'h7FFF, 0);
    check("R1 short", int'(mix_code), 0);
    send(0, 17, 32'h1FFFF, 0);
    check("R1 long", int'(mix_code), 0);

    send(1, 16, 32'hA5C3, 0);
    check("R10 tx load", int'(tx_level), 16'hA5C3);
    check("R10 lna kept", int'(lna_code), 3);
    check("R10 req kept", int'(oc_req), 1);

    send(0, 16, 32'hF000, 1);
    check("R11 clash", int'(mix_code), 0);
    send(1, 16, 32'h1234, 1);
    check("R11 clash tx", int'(tx_level), 16'hA5C3);

    repeat (4) @(negedge clk);
    done_all = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule